// File: doc/BRIEF.md
# DRAM Strobe Cycle Classifier

This block watches the four active-low control strobes of an asynchronous fast-page-mode DRAM (row strobe, column strobe, write enable, output enable) on a fast system clock. It never drives the memory. For each row-strobe low period it issues one report giving the kind of memory cycle and the number of extra page-mode column accesses in it. It is meant as a bus monitor or as a protocol checker next to a DRAM controller.

All four strobes pass through two-flop synchronizers before any edge is detected. The cycle kind depends on the order of the synchronized edges. A column access that starts with write enable already low is an early write. A write-enable fall during the column strobe is a delayed write, or a read-modify-write if output enable was low first. A row fall with the column strobe already low is a refresh. That refresh is a hidden refresh when the column strobe has stayed low since the end of a read.

The block also keeps a sticky wake-up flag. The flag shows that the device has seen no row activity for too long and must receive a number of dummy cycles before normal use. The flag also stands from reset, because a device must get the same dummy cycles after power-up.

Top module: `fpm_cycle_monitor`

## Requirements
- R1: After reset `cyc_done_o` is 0, `cyc_type_o` is 0, `page_count_o` is 0 and `wake_req_o` is 1.
- R2: One report is made per row-strobe low period. `cyc_done_o` is high for exactly one clock, on the third rising clock edge after the raw row strobe rises. `cyc_type_o` and `page_count_o` are updated at that edge and hold until the next report.
- R3: Type code 1 (read) is reported when write enable stays high for the whole first column-strobe low period.
- R4: Type code 2 (early write) is reported when write enable is low when the first column strobe falls, or falls on the same sampled clock.
- R5: Type code 3 (delayed write) is reported when write enable falls during the first column-strobe low period and output enable was not low at any point in that period up to the fall.
- R6: Type code 4 (read-modify-write) is reported when write enable falls during the first column-strobe low period after output enable was low in that period, or together with output enable being low.
- R7: Type code 5 (refresh with column strobe first) is reported when the column strobe is already low at the row-strobe fall. Write enable must be high at that row-strobe fall. Column-strobe toggling inside such a cycle is ignored, so `page_count_o` is 0.
- R8: Type code 6 (hidden refresh) is reported instead of code 5 when the column strobe has been low without a break since the end of a cycle reported as code 1 or code 6.
- R9: Type code 0 (standby) is reported for a row-strobe low period with no column-strobe fall. No report is made while the row strobe stays high.
- R10: `page_count_o` is the number of column-strobe falls after the first one within the row-strobe low period. It saturates at 2^PAGE_CNT_W - 1.
- R11: Only the first column access decides the type. Write-enable activity in later page-mode accesses does not change the reported type.
- R12: `wake_req_o` is set once the synchronized row strobe has been high for IDLE_CYCLES consecutive clocks.
- R13: While set, `wake_req_o` clears after WAKE_CYCLES reports of any type. Fewer reports leave it set, and each new setting restarts this count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n_i | input | 1 | Row strobe, active low, asynchronous |
| cas_n_i | input | 1 | Column strobe, active low, asynchronous |
| we_n_i | input | 1 | Write enable, active low, asynchronous |
| oe_n_i | input | 1 | Output enable, active low, asynchronous |
| cyc_done_o | output | 1 | One-clock report strobe |
| cyc_type_o | output | 3 | Cycle kind code (0..6) |
| page_count_o | output | PAGE_CNT_W | Extra column accesses in the reported cycle |
| wake_req_o | output | 1 | Sticky flag: dummy cycles needed |

## Verification
The assertions assume that each strobe level is held for at least two sampling clocks, so that every edge is seen in order after synchronization. They also assume that write enable is high whenever the row strobe falls with the column strobe low. The stimulus changes only one group of strobes at a time, on the falling clock edge, holds every level for four clocks, and keeps write enable high at every refresh entry. The random mix draws only among the four access flavours with up to three extra page accesses, and some of those extra accesses carry write-enable pulses.

// File: rtl/fpm_mon_pkg.sv
package fpm_mon_pkg;

    typedef enum logic [2:0] {
        CYC_IDLE     = 3'd0,
        CYC_READ     = 3'd1,
        CYC_WR_EARLY = 3'd2,
        CYC_WR_LATE  = 3'd3,
        CYC_RMW      = 3'd4,
        CYC_CBR      = 3'd5,
        CYC_HIDDEN   = 3'd6
    } cyc_kind_e;

    localparam int NUM_STROBES = 4;
    localparam int IX_RAS = 0;
    localparam int IX_CAS = 1;
    localparam int IX_WE  = 2;
    localparam int IX_OE  = 3;

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d.s1 = raw_i;
        d.s2 = q.s1;
    end

    // strobes are active low: idle value is all ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.s1 <= '1;
            q.s2 <= '1;
        end else begin
            q <= d;
        end
    end

    assign sync_o = q.s2;
endmodule

// File: rtl/cycle_classifier.sv
module cycle_classifier
    import fpm_mon_pkg::*;
#(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ras_i,
    input  logic          cas_i,
    input  logic          we_i,
    input  logic          oe_i,
    output logic          done_o,
    output cyc_kind_e     kind_o,
    output logic [PW-1:0] count_o
);
    localparam int NW = PW + 1;
    localparam logic [NW-1:0] N_MAX = NW'(2 ** PW);

    typedef struct packed {
        logic          ras_p;
        logic          cas_p;
        logic          we_p;
        cyc_kind_e     kind;
        logic          locked;
        logic          oe_seen;
        logic [NW-1:0] n;
        logic          hid;
        logic          done;
        cyc_kind_e     rep_kind;
        logic [PW-1:0] rep_cnt;
    } cls_t;

    cls_t d, q;
    logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall, is_refresh;

    always_comb begin
        ras_fall   = q.ras_p & ~ras_i;
        ras_rise   = ~q.ras_p & ras_i;
        cas_fall   = q.cas_p & ~cas_i;
        cas_rise   = ~q.cas_p & cas_i;
        we_fall    = q.we_p & ~we_i;
        is_refresh = (q.kind == CYC_CBR) || (q.kind == CYC_HIDDEN);

        d       = q;
        d.done  = 1'b0;
        d.ras_p = ras_i;
        d.cas_p = cas_i;
        d.we_p  = we_i;

        if (cas_rise) d.hid = 1'b0;

        if (ras_fall) begin
            d.n       = '0;
            d.oe_seen = 1'b0;
            if (!cas_i) begin
                d.kind   = q.hid ? CYC_HIDDEN : CYC_CBR;
                d.locked = 1'b1;
            end else begin
                d.kind   = CYC_IDLE;
                d.locked = 1'b0;
            end
        end else if (!ras_i) begin
            if (cas_fall && !is_refresh) begin
                if (q.n != N_MAX) d.n = q.n + 1'b1;
                if (q.n == '0) begin
                    if (!we_i) begin
                        d.kind   = CYC_WR_EARLY;
                        d.locked = 1'b1;
                    end else begin
                        d.kind = CYC_READ;
                    end
                    if (!oe_i) d.oe_seen = 1'b1;
                end
            end else if ((q.n == NW'(1)) && !cas_i && !q.locked) begin
                if (!oe_i) d.oe_seen = 1'b1;
                if (we_fall) begin
                    d.kind   = (q.oe_seen || !oe_i) ? CYC_RMW : CYC_WR_LATE;
                    d.locked = 1'b1;
                end
            end
        end

        if (ras_rise) begin
            d.done     = 1'b1;
            d.rep_kind = q.kind;
            d.rep_cnt  = (q.n == '0) ? '0 : PW'(q.n - 1'b1);
            if (!cas_i && ((q.kind == CYC_READ) || (q.kind == CYC_HIDDEN)))
                d.hid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ras_p    <= 1'b1;
            q.cas_p    <= 1'b1;
            q.we_p     <= 1'b1;
            q.kind     <= CYC_IDLE;
            q.locked   <= 1'b0;
            q.oe_seen  <= 1'b0;
            q.n        <= '0;
            q.hid      <= 1'b0;
            q.done     <= 1'b0;
            q.rep_kind <= CYC_IDLE;
            q.rep_cnt  <= '0;
        end else begin
            q <= d;
        end
    end

    assign done_o  = q.done;
    assign kind_o  = q.rep_kind;
    assign count_o = q.rep_cnt;

    // R2: a report lasts one clock
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    // R7: refresh reports never carry page accesses
    p_refresh_no_pages_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && ((q.rep_kind == CYC_CBR) || (q.rep_kind == CYC_HIDDEN)))
        |-> (q.rep_cnt == '0));

    // R7: input rule, write enable high when a refresh is entered
    p_cbr_we_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ras_p && !ras_i && !cas_i) |-> we_i);

    // R8: a hidden refresh is only entered while the column strobe is low
    p_hidden_cas_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($changed(q.kind) && (q.kind == CYC_HIDDEN)) |-> $past(!cas_i));
endmodule

// File: rtl/wake_tracker.sv
module wake_tracker #(
    parameter int IDLE_CYCLES = 6400000,
    parameter int WAKE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_low_i,
    input  logic done_i,
    output logic wake_o
);
    localparam int IW = $clog2(IDLE_CYCLES + 1);
    localparam int QW = $clog2(WAKE_CYCLES + 1);
    localparam logic [IW-1:0] IDLE_LIM = IW'(IDLE_CYCLES);
    localparam logic [QW-1:0] Q_LAST   = QW'(WAKE_CYCLES - 1);

    typedef struct packed {
        logic [IW-1:0] idle;
        logic [QW-1:0] qual;
        logic          wake;
    } wk_t;

    wk_t d, q;

    always_comb begin
        d = q;
        if (q.wake && done_i) begin
            if (q.qual == Q_LAST) begin
                d.wake = 1'b0;
                d.qual = '0;
            end else begin
                d.qual = q.qual + 1'b1;
            end
        end
        if (ras_low_i) begin
            d.idle = '0;
        end else if (q.idle != IDLE_LIM) begin
            d.idle = q.idle + 1'b1;
            if (d.idle == IDLE_LIM) begin
                d.wake = 1'b1;
                d.qual = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.idle <= '0;
            q.qual <= '0;
            q.wake <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign wake_o = q.wake;

    // R12: the flag rises only after a clock with the row strobe idle
    p_wake_set_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.wake) |-> $past(!ras_low_i));

    // R13: the flag falls only on a report
    p_wake_clear_done_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.wake) |-> $past(done_i));
endmodule

// File: rtl/fpm_cycle_monitor.sv
module fpm_cycle_monitor
    import fpm_mon_pkg::*;
#(
    parameter int PAGE_CNT_W  = 4,
    parameter int IDLE_CYCLES = 6400000,
    parameter int WAKE_CYCLES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ras_n_i,
    input  logic                  cas_n_i,
    input  logic                  we_n_i,
    input  logic                  oe_n_i,
    output logic                  cyc_done_o,
    output logic [2:0]            cyc_type_o,
    output logic [PAGE_CNT_W-1:0] page_count_o,
    output logic                  wake_req_o
);
    logic [NUM_STROBES-1:0] raw, syn;
    cyc_kind_e kind;
    logic done;

    always_comb begin
        raw         = '1;
        raw[IX_RAS] = ras_n_i;
        raw[IX_CAS] = cas_n_i;
        raw[IX_WE]  = we_n_i;
        raw[IX_OE]  = oe_n_i;
    end

    strobe_sync #(.WIDTH(NUM_STROBES)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (raw),
        .sync_o (syn)
    );

    cycle_classifier #(.PW(PAGE_CNT_W)) cls_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ras_i   (syn[IX_RAS]),
        .cas_i   (syn[IX_CAS]),
        .we_i    (syn[IX_WE]),
        .oe_i    (syn[IX_OE]),
        .done_o  (done),
        .kind_o  (kind),
        .count_o (page_count_o)
    );

    wake_tracker #(.IDLE_CYCLES(IDLE_CYCLES), .WAKE_CYCLES(WAKE_CYCLES)) wake_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ras_low_i (~syn[IX_RAS]),
        .done_i    (done),
        .wake_o    (wake_req_o)
    );

    assign cyc_done_o = done;
    assign cyc_type_o = kind;
endmodule

// File: tb/fpm_cycle_monitor_tb.sv
module fpm_cycle_monitor_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PW   = 3;
    localparam int IDLE = 300;
    localparam int WAKE = 8;

    localparam int F_READ  = 0;
    localparam int F_EARLY = 1;
    localparam int F_LATE  = 2;
    localparam int F_RMW   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic          cyc_done;
    logic [2:0]    cyc_type;
    logic [PW-1:0] page_count;
    logic          wake_req;

    int checks = 0;
    int errors = 0;
    int exp_reports = 0;
    int seen_reports = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpm_cycle_monitor #(.PAGE_CNT_W(PW), .IDLE_CYCLES(IDLE), .WAKE_CYCLES(WAKE)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ras_n_i      (ras_n),
        .cas_n_i      (cas_n),
        .we_n_i       (we_n),
        .oe_n_i       (oe_n),
        .cyc_done_o   (cyc_done),
        .cyc_type_o   (cyc_type),
        .page_count_o (page_count),
        .wake_req_o   (wake_req)
    );

    always @(negedge clk) if (rst_n && cyc_done) seen_reports++;

    function automatic int exp_code(int flavour);
        case (flavour)
            F_READ:  return 1;
            F_EARLY: return 2;
            F_LATE:  return 3;
            default: return 4;
        endcase
    endfunction

    function automatic int exp_pages(int extra);
        int lim = (1 << PW) - 1;
        return (extra > lim) ? lim : extra;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic end_cycle(string req, int etype, int ecnt);
        ras_n = 1'b1;
        repeat (3) @(negedge clk);
        check({req, " R2 done"}, int'(cyc_done), 1);
        check({req, " type"}, int'(cyc_type), etype);
        check({req, " page count"}, int'(page_count), ecnt);
        exp_reports++;
        @(negedge clk);
        check("R2 done one clock", int'(cyc_done), 0);
        check("R2 type held", int'(cyc_type), etype);
        step(3);
    endtask

    task automatic first_access(int flavour);
        case (flavour)
            F_READ: begin
                cas_n = 1'b0; step(4);
                oe_n = 1'b0;  step(4);
                oe_n = 1'b1; cas_n = 1'b1; step(4);
            end
            F_EARLY: begin
                we_n = 1'b0;  step(4);
                cas_n = 1'b0; step(4);
                cas_n = 1'b1; we_n = 1'b1; step(4);
            end
            F_LATE: begin
                cas_n = 1'b0; step(4);
                we_n = 1'b0;  step(4);
                we_n = 1'b1;  step(4);
                cas_n = 1'b1; step(4);
            end
            default: begin
                cas_n = 1'b0; step(4);
                oe_n = 1'b0;  step(4);
                oe_n = 1'b1;  step(4);
                we_n = 1'b0;  step(4);
                we_n = 1'b1; cas_n = 1'b1; step(4);
            end
        endcase
    endtask

    task automatic page_cycle(string req, int flavour, int extra, bit wr_noise);
        ras_n = 1'b0; step(4);
        first_access(flavour);
        for (int i = 0; i < extra; i++) begin
            cas_n = 1'b0; step(4);
            if (wr_noise) begin
                we_n = 1'b0; step(4);
                we_n = 1'b1; step(4);
            end
            cas_n = 1'b1; step(4);
        end
        end_cycle(req, exp_code(flavour), exp_pages(extra));
    endtask

    initial begin
        void'($urandom(32'd2024));
        step(5);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done", int'(cyc_done), 0);
        check("R1 type", int'(cyc_type), 0);
        check("R1 count", int'(page_count), 0);
        check("R1 wake", int'(wake_req), 1);

        // R13: seven reports leave the flag set, the eighth clears it
        for (int i = 0; i < 7; i++) page_cycle("R3 read", F_READ, 0, 1'b0);
        check("R13 wake after seven", int'(wake_req), 1);
        ras_n = 1'b0; step(4);
        end_cycle("R9 standby", 0, 0);
        step(2);
        check("R13 wake after eight", int'(wake_req), 0);

        page_cycle("R3 read", F_READ, 0, 1'b0);
        page_cycle("R4 early write", F_EARLY, 0, 1'b0);
        page_cycle("R5 delayed write", F_LATE, 0, 1'b0);
        page_cycle("R6 read-modify-write", F_RMW, 0, 1'b0);
        page_cycle("R10 pages", F_READ, 2, 1'b0);
        page_cycle("R11 later writes ignored", F_READ, 2, 1'b1);
        page_cycle("R10 saturation", F_EARLY, 10, 1'b0);

        // R7: refresh with column strobe first; toggling inside is not counted
        cas_n = 1'b0; step(4);
        ras_n = 1'b0; step(4);
        cas_n = 1'b1; step(4);
        cas_n = 1'b0; step(4);
        end_cycle("R7 refresh", 5, 0);
        cas_n = 1'b1; step(4);

        // R8: read ending with column strobe held low, then two hidden refreshes
        ras_n = 1'b0; step(4);
        cas_n = 1'b0; step(4);
        oe_n = 1'b0;  step(4);
        end_cycle("R8 read before hidden", 1, 0);
        ras_n = 1'b0; step(4);
        end_cycle("R8 hidden", 6, 0);
        ras_n = 1'b0; step(4);
        end_cycle("R8 hidden again", 6, 0);
        oe_n = 1'b1; cas_n = 1'b1; step(4);
        // a column-strobe break turns the next such entry into a plain refresh
        cas_n = 1'b0; step(4);
        ras_n = 1'b0; step(4);
        end_cycle("R8 break gives R7 code", 5, 0);
        cas_n = 1'b1; step(4);

        // R9: long row-high stretch produces no report
        step(40);
        check("R9 no spurious report", seen_reports, exp_reports);

        for (int r = 0; r < 60; r++) begin
            int fl = int'($urandom_range(0, 3));
            int ex = int'($urandom_range(0, 3));
            bit nz = 1'($urandom_range(0, 1));
            page_cycle("R3-style random", fl, ex, nz);
        end
        check("R13 wake stays clear", int'(wake_req), 0);

        // R12: idle just below the limit, then past it
        step(IDLE - 120);
        check("R12 below limit", int'(wake_req), 0);
        step(140);
        check("R12 past limit", int'(wake_req), 1);
        page_cycle("R13 one report after set", F_RMW, 1, 1'b0);
        check("R13 wake restarted count", int'(wake_req), 1);

        check("R2 report count", seen_reports, exp_reports);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule